// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block holds the results of instructions that have been issued but not yet retired, so that a core executing out of order still retires in program order. At issue time an instruction claims the next free slot. The slot index is returned as the tag under which the instruction's result will later be broadcast. Execution units broadcast finished results by tag. Any slot that holds a result can serve as an operand source before it retires.

The oldest slot retires once its result is present. Retirement either writes the register file, performs a store, or only frees the slot. A branch that was found to be mispredicted, or an instruction that faulted, discards every younger slot when it reaches the oldest position. A separate kill input empties the buffer at once.

The depth is a parameter with a default of 16. Register-number and data widths come from the shared package.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: nothing retires, every tag lookup reports not ready, and the first accepted allocation returns tag 0.
- R2: Each accepted allocation returns the tag one above the previous accepted one, wrapping from DEPTH-1 to 0, unless a flush or kill happened in between. An allocation is accepted (alloc_ok high) only while alloc_req is high.
- R3: With DEPTH slots occupied and the oldest not retiring, an allocation request is refused (alloc_ok low).
- R4: A writeback to a live tag marks that slot ready, and a lookup of that tag then returns ready with the written value. A writeback to a tag with no live slot is ignored, and a lookup of that tag stays not ready.
- R5: Only the oldest slot retires, and only once its result is present. Retirement follows allocation order even when younger results arrive first. All retire strobes are low when nothing retires.
- R6: The kind code is 2'b00 for a register-writing operation, 2'b01 for a store and 2'b10 for a branch. A retiring 2'b00 slot raises commit_reg_we with its destination and value. A 2'b01 slot raises commit_store_en. A correctly predicted branch raises neither.
- R7: A branch written back with the mispredict flag retires with commit_flush high. Every younger slot is discarded and reports not ready. The next accepted allocation takes the tag after the branch.
- R8: A slot written back with the fault flag retires with commit_exception and commit_flush high, with neither commit_reg_we nor commit_store_en. All younger slots are discarded and the next tag follows the faulting one.
- R9: While kill is high nothing retires. From the next cycle the buffer is empty, and the next accepted allocation reuses the tag of the oldest discarded slot.
- R10: When the buffer is full and the oldest slot retires in a cycle, an allocation in that same cycle is accepted and receives the freed tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kill | input | 1 | Discard all slots immediately |
| alloc_req | input | 1 | Issue stage requests a slot |
| alloc_kind | input | 2 | Kind of the issuing instruction |
| alloc_dest | input | 5 | Destination register number or store target |
| alloc_ok | output | 1 | Request accepted this cycle |
| alloc_tag | output | 4 | Tag given to the accepted instruction |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | 4 | Tag of the broadcast result |
| wb_value | input | 32 | Broadcast result value |
| wb_mispredict | input | 1 | Branch outcome disagreed with prediction |
| wb_fault | input | 1 | Instruction raised a fault |
| src_tag | input | 4 | Tag of a pending operand |
| src_ready | output | 1 | Looked-up slot holds its result |
| src_value | output | 32 | Value of the looked-up slot |
| commit_valid | output | 1 | Oldest slot retires this cycle |
| commit_kind | output | 2 | Kind of the retiring slot |
| commit_dest | output | 5 | Destination of the retiring slot |
| commit_value | output | 32 | Value of the retiring slot |
| commit_reg_we | output | 1 | Register file write |
| commit_store_en | output | 1 | Store to memory |
| commit_exception | output | 1 | Retiring slot faulted |
| commit_flush | output | 1 | Younger slots are discarded |

## Verification
The bench delivers results youngest first. A design that retired whatever was ready would break the scoreboard order. It fills the buffer across the index wrap and then asks for one slot too many. A wrong full test either overwrites a live slot or refuses the slot freed by a simultaneous retirement. Flush cases check that younger slots already holding results never retire, that they stop answering lookups, and that the next tag follows the squashing slot. A design that only moved the tail, or that kept valid bits, would leak stale results. The kill case issues kill in the same cycle as a ready oldest slot, which catches a retirement that is not gated.

// File: rtl/rob_pkg.sv
package rob_pkg;
    parameter int ROB_DATA_W = 32;
    parameter int ROB_REG_W  = 5;

    typedef enum logic [1:0] {
        OP_ALU    = 2'b00,
        OP_STORE  = 2'b01,
        OP_BRANCH = 2'b10
    } op_kind_e;

    typedef struct packed {
        logic                  busy;
        logic                  done;
        op_kind_e              kind;
        logic [ROB_REG_W-1:0]  dest;
        logic [ROB_DATA_W-1:0] value;
        logic                  mispredict;
        logic                  fault;
    } rob_slot_t;

    // A slot that discards everything younger when it retires
    function automatic logic squashes(rob_slot_t s);
        return s.fault || (s.kind == OP_BRANCH && s.mispredict);
    endfunction
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl #(
    parameter int DEPTH = 16,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kill,
    input  logic             alloc_req,
    input  logic             head_busy,
    input  logic             head_done,
    input  logic             head_squash,
    output logic [TAG_W-1:0] head_idx,
    output logic [TAG_W-1:0] tail_idx,
    output logic             alloc_fire,
    output logic             commit_fire,
    output logic             clear_all
);
    logic [CNT_W-1:0] occ;
    logic             squash;
    logic             full;

    function automatic logic [TAG_W-1:0] bump(logic [TAG_W-1:0] x);
        return (x == TAG_W'(DEPTH - 1)) ? '0 : x + 1'b1;
    endfunction

    always_comb begin
        commit_fire = head_busy && head_done && !kill;
        squash      = commit_fire && head_squash;
        clear_all   = kill || squash;
        full        = (occ == CNT_W'(DEPTH));
        alloc_fire  = alloc_req && !clear_all && (!full || commit_fire);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_idx <= '0;
            tail_idx <= '0;
            occ      <= '0;
        end else if (kill) begin
            tail_idx <= head_idx;
            occ      <= '0;
        end else if (squash) begin
            head_idx <= bump(head_idx);
            tail_idx <= bump(head_idx);
            occ      <= '0;
        end else begin
            if (commit_fire) head_idx <= bump(head_idx);
            if (alloc_fire)  tail_idx <= bump(tail_idx);
            case ({alloc_fire, commit_fire})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/rob_slots.sv
module rob_slots import rob_pkg::*; #(
    parameter int DEPTH = 16,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear_all,
    input  logic                  alloc_fire,
    input  logic [TAG_W-1:0]      tail_idx,
    input  op_kind_e              alloc_kind,
    input  logic [ROB_REG_W-1:0]  alloc_dest,
    input  logic                  commit_fire,
    input  logic [TAG_W-1:0]      head_idx,
    input  logic                  wb_valid,
    input  logic [TAG_W-1:0]      wb_tag,
    input  logic [ROB_DATA_W-1:0] wb_value,
    input  logic                  wb_mispredict,
    input  logic                  wb_fault,
    input  logic [TAG_W-1:0]      look_tag,
    output rob_slot_t             head_slot,
    output logic                  look_done,
    output logic [ROB_DATA_W-1:0] look_value
);
    rob_slot_t slots [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (clear_all) begin
                slots[i].busy <= 1'b0;
                slots[i].done <= 1'b0;
            end else if (alloc_fire && tail_idx == TAG_W'(i)) begin
                slots[i] <= '{busy: 1'b1, done: 1'b0, kind: alloc_kind,
                              dest: alloc_dest, value: '0,
                              mispredict: 1'b0, fault: 1'b0};
            end else if (commit_fire && head_idx == TAG_W'(i)) begin
                slots[i].busy <= 1'b0;
                slots[i].done <= 1'b0;
            end else if (wb_valid && wb_tag == TAG_W'(i) && slots[i].busy) begin
                slots[i].done       <= 1'b1;
                slots[i].value      <= wb_value;
                slots[i].mispredict <= wb_mispredict;
                slots[i].fault      <= wb_fault;
            end
        end
    end

    always_comb begin
        head_slot  = slots[head_idx];
        look_done  = slots[look_tag].busy && slots[look_tag].done;
        look_value = slots[look_tag].value;
    end
endmodule

// File: rtl/spec_rob.sv
module spec_rob import rob_pkg::*; #(
    parameter int DEPTH = 16,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  kill,
    input  logic                  alloc_req,
    input  logic [1:0]            alloc_kind,
    input  logic [ROB_REG_W-1:0]  alloc_dest,
    output logic                  alloc_ok,
    output logic [TAG_W-1:0]      alloc_tag,
    input  logic                  wb_valid,
    input  logic [TAG_W-1:0]      wb_tag,
    input  logic [ROB_DATA_W-1:0] wb_value,
    input  logic                  wb_mispredict,
    input  logic                  wb_fault,
    input  logic [TAG_W-1:0]      src_tag,
    output logic                  src_ready,
    output logic [ROB_DATA_W-1:0] src_value,
    output logic                  commit_valid,
    output logic [1:0]            commit_kind,
    output logic [ROB_REG_W-1:0]  commit_dest,
    output logic [ROB_DATA_W-1:0] commit_value,
    output logic                  commit_reg_we,
    output logic                  commit_store_en,
    output logic                  commit_exception,
    output logic                  commit_flush
);
    logic [TAG_W-1:0] head_idx, tail_idx;
    logic             alloc_fire, commit_fire, clear_all;
    rob_slot_t        head_slot;

    rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .kill        (kill),
        .alloc_req   (alloc_req),
        .head_busy   (head_slot.busy),
        .head_done   (head_slot.done),
        .head_squash (squashes(head_slot)),
        .head_idx    (head_idx),
        .tail_idx    (tail_idx),
        .alloc_fire  (alloc_fire),
        .commit_fire (commit_fire),
        .clear_all   (clear_all)
    );

    rob_slots #(.DEPTH(DEPTH)) u_slots (
        .clk           (clk),
        .rst           (rst),
        .clear_all     (clear_all),
        .alloc_fire    (alloc_fire),
        .tail_idx      (tail_idx),
        .alloc_kind    (op_kind_e'(alloc_kind)),
        .alloc_dest    (alloc_dest),
        .commit_fire   (commit_fire),
        .head_idx      (head_idx),
        .wb_valid      (wb_valid),
        .wb_tag        (wb_tag),
        .wb_value      (wb_value),
        .wb_mispredict (wb_mispredict),
        .wb_fault      (wb_fault),
        .look_tag      (src_tag),
        .head_slot     (head_slot),
        .look_done     (src_ready),
        .look_value    (src_value)
    );

    always_comb begin
        alloc_ok         = alloc_fire;
        alloc_tag        = tail_idx;
        commit_valid     = commit_fire;
        commit_kind      = head_slot.kind;
        commit_dest      = head_slot.dest;
        commit_value     = head_slot.value;
        commit_reg_we    = commit_fire && head_slot.kind == OP_ALU   && !head_slot.fault;
        commit_store_en  = commit_fire && head_slot.kind == OP_STORE && !head_slot.fault;
        commit_exception = commit_fire && head_slot.fault;
        commit_flush     = commit_fire && squashes(head_slot);
    end
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
    parameter int DEPTH = 16,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             kill,
    input logic             alloc_req,
    input logic             alloc_ok,
    input logic [TAG_W-1:0] alloc_tag,
    input logic             src_ready,
    input logic             commit_valid,
    input logic             commit_reg_we,
    input logic             commit_store_en,
    input logic             commit_exception,
    input logic             commit_flush
);
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        alloc_ok |-> alloc_req); // R2

    AST_TAG_STEP: assert property (@(posedge clk) disable iff (rst)
        (alloc_ok && $past(alloc_ok) && !$past(rst) && !$past(kill) && !$past(commit_flush))
        |-> alloc_tag == (($past(alloc_tag) == TAG_W'(DEPTH - 1)) ? '0 : $past(alloc_tag) + 1'b1)); // R2

    AST_ONE_SINK: assert property (@(posedge clk) disable iff (rst)
        $onehot0({commit_reg_we, commit_store_en, commit_exception})); // R6

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !commit_valid |-> !commit_reg_we && !commit_store_en && !commit_exception && !commit_flush); // R5

    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        commit_exception |-> commit_flush && !commit_reg_we && !commit_store_en); // R8

    AST_FLUSH_DRAINS: assert property (@(posedge clk) disable iff (rst)
        commit_flush |=> !commit_valid && !src_ready); // R7

    AST_KILL_DRAINS: assert property (@(posedge clk) disable iff (rst)
        kill |=> !commit_valid && !src_ready); // R9
endmodule

bind spec_rob rob_checker #(.DEPTH(DEPTH)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .kill             (kill),
    .alloc_req        (alloc_req),
    .alloc_ok         (alloc_ok),
    .alloc_tag        (alloc_tag),
    .src_ready        (src_ready),
    .commit_valid     (commit_valid),
    .commit_reg_we    (commit_reg_we),
    .commit_store_en  (commit_store_en),
    .commit_exception (commit_exception),
    .commit_flush     (commit_flush)
);

// File: tb/sim_spec_rob.sv
`timescale 1ns/1ps
module sim_spec_rob;
    localparam int DEPTH = 16;
    localparam logic [1:0] K_ALU = 2'b00, K_ST = 2'b01, K_BR = 2'b10;

    logic        clk = 1'b0, rst = 1'b1, kill = 1'b0;
    logic        alloc_req = 1'b0;
    logic [1:0]  alloc_kind = '0;
    logic [4:0]  alloc_dest = '0;
    logic        alloc_ok;
    logic [3:0]  alloc_tag;
    logic        wb_valid = 1'b0, wb_mispredict = 1'b0, wb_fault = 1'b0;
    logic [3:0]  wb_tag = '0;
    logic [31:0] wb_value = '0;
    logic [3:0]  src_tag = '0;
    logic        src_ready;
    logic [31:0] src_value;
    logic        commit_valid, commit_reg_we, commit_store_en, commit_exception, commit_flush;
    logic [1:0]  commit_kind;
    logic [4:0]  commit_dest;
    logic [31:0] commit_value;

    always #2.5 clk = ~clk;

    spec_rob #(.DEPTH(DEPTH)) u0 (.*);

    int total = 0, bad = 0, nxt = 0;
    logic [1:0]  e_kind [DEPTH];
    logic [4:0]  e_dest [DEPTH];
    logic [31:0] e_val  [DEPTH];
    logic        e_mis  [DEPTH];
    logic        e_flt  [DEPTH];
    int order_q[$];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_alloc(logic [1:0] k, logic [4:0] d, bit exp_ok, bit keep, string req);
        alloc_req = 1'b1; alloc_kind = k; alloc_dest = d;
        #1;
        chk(req, "alloc_ok", 32'(alloc_ok), 32'(exp_ok));
        if (exp_ok) chk(req, "alloc_tag", 32'(alloc_tag), 32'(nxt));
        @(posedge clk);
        if (exp_ok) begin
            e_kind[nxt] = k; e_dest[nxt] = d; e_mis[nxt] = 1'b0; e_flt[nxt] = 1'b0;
            if (keep) order_q.push_back(nxt);
            nxt = (nxt + 1) % DEPTH;
        end
        #1; alloc_req = 1'b0;
    endtask

    task automatic do_wb(int t, logic [31:0] v, bit mis, bit flt, bit rec);
        wb_valid = 1'b1; wb_tag = 4'(t); wb_value = v; wb_mispredict = mis; wb_fault = flt;
        if (rec) begin e_val[t] = v; e_mis[t] = mis; e_flt[t] = flt; end
        step();
        wb_valid = 1'b0; wb_mispredict = 1'b0; wb_fault = 1'b0;
    endtask

    task automatic look(int t, bit exp_rdy, logic [31:0] exp_v, string req);
        src_tag = 4'(t);
        #1;
        chk(req, "src_ready", 32'(src_ready), 32'(exp_rdy));
        if (exp_rdy) chk(req, "src_value", src_value, exp_v);
        step();
    endtask

    task automatic drain();
        for (int i = 0; i < 60 && order_q.size() != 0; i++) step();
        step();
        chk("R5", "scoreboard drained", 32'(order_q.size()), 32'd0);
    endtask

    // Monitor: compare each retirement against the oldest expected item
    always @(negedge clk) begin
        if (!rst && commit_valid) begin
            if (order_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R5 unexpected retirement actual=%0h expected=none", commit_dest);
            end else begin
                int t;
                bit we, st, ex, fl;
                t  = order_q.pop_front();
                ex = e_flt[t];
                we = (e_kind[t] == K_ALU) && !ex;
                st = (e_kind[t] == K_ST) && !ex;
                fl = ex || (e_kind[t] == K_BR && e_mis[t]);
                chk("R5", "commit_kind", 32'(commit_kind), 32'(e_kind[t]));
                chk("R5", "commit_dest", 32'(commit_dest), 32'(e_dest[t]));
                if (we || st) chk("R5", "commit_value", commit_value, e_val[t]);
                chk("R6", "commit_reg_we", 32'(commit_reg_we), 32'(we));
                chk("R6", "commit_store_en", 32'(commit_store_en), 32'(st));
                chk("R8", "commit_exception", 32'(commit_exception), 32'(ex));
                chk("R7", "commit_flush", 32'(commit_flush), 32'(fl));
            end
        end
    end

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(5.0 * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        int b, x, y, f, g, a;
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
        // R1: empty after reset
        #1;
        chk("R1", "commit_valid after reset", 32'(commit_valid), 32'd0);
        chk("R1", "src_ready after reset", 32'(src_ready), 32'd0);
        step();
        do_alloc(K_ALU, 5'd1, 1, 1, "R1");
        do_alloc(K_ALU, 5'd2, 1, 1, "R2");
        do_alloc(K_ALU, 5'd3, 1, 1, "R2");
        // R4 / R5: youngest result first, head not ready yet
        do_wb(2, 32'hA2, 0, 0, 1);
        chk("R5", "no retirement while oldest pending", 32'(commit_valid), 32'd0);
        look(2, 1, 32'hA2, "R4");
        look(0, 0, 32'h0, "R4");
        do_wb(9, 32'hDEAD, 0, 0, 0);
        look(9, 0, 32'h0, "R4");
        do_wb(0, 32'hA0, 0, 0, 1);
        do_wb(1, 32'hA1, 0, 0, 1);
        drain();
        // R6: store and correctly predicted branch
        do_alloc(K_ST, 5'd7, 1, 1, "R6");
        do_alloc(K_BR, 5'd0, 1, 1, "R6");
        do_wb(4, 32'h44, 0, 0, 1);
        do_wb(3, 32'h33, 0, 0, 1);
        drain();
        // R3 / R10: fill across the wrap, refuse one, then retire-and-allocate
        for (int i = 0; i < DEPTH; i++) do_alloc(K_ALU, 5'(i + 8), 1, 1, "R2");
        do_alloc(K_ALU, 5'd31, 0, 0, "R3");
        do_wb(5, 32'h100, 0, 0, 1);
        do_alloc(K_ALU, 5'd20, 1, 1, "R10");
        for (int j = 1; j <= DEPTH; j++) do_wb((5 + j) % DEPTH, 32'h100 + 32'(j), 0, 0, 1);
        drain();
        // R7: mispredicted branch squashes ready younger slots
        b = nxt; x = (b + 1) % DEPTH; y = (b + 2) % DEPTH;
        do_alloc(K_BR, 5'd0, 1, 1, "R7");
        do_alloc(K_ALU, 5'd9, 1, 0, "R7");
        do_alloc(K_ALU, 5'd10, 1, 0, "R7");
        do_wb(y, 32'hBB, 0, 0, 1);
        do_wb(x, 32'hAA, 0, 0, 1);
        look(x, 1, 32'hAA, "R4");
        do_wb(b, 32'h0, 1, 0, 1);
        step();
        look(x, 0, 32'h0, "R7");
        look(y, 0, 32'h0, "R7");
        nxt = x;
        do_alloc(K_ALU, 5'd11, 1, 1, "R7");
        do_wb(x, 32'hC1, 0, 0, 1);
        drain();
        // R8: faulting slot
        f = nxt; g = (f + 1) % DEPTH;
        do_alloc(K_ALU, 5'd12, 1, 1, "R8");
        do_alloc(K_ALU, 5'd13, 1, 0, "R8");
        do_wb(g, 32'h66, 0, 0, 1);
        do_wb(f, 32'h55, 0, 1, 1);
        step();
        look(g, 0, 32'h0, "R8");
        nxt = g;
        do_alloc(K_ST, 5'd14, 1, 1, "R8");
        do_wb(g, 32'h77, 0, 0, 1);
        drain();
        // R9: kill while the oldest slot is ready
        a = nxt;
        do_alloc(K_ALU, 5'd15, 1, 0, "R9");
        do_alloc(K_ALU, 5'd16, 1, 0, "R9");
        do_wb(a, 32'h88, 0, 0, 1);
        kill = 1'b1;
        #1;
        chk("R9", "retirement suppressed by kill", 32'(commit_valid), 32'd0);
        step();
        kill = 1'b0;
        look(a, 0, 32'h0, "R9");
        nxt = a;
        do_alloc(K_ALU, 5'd17, 1, 1, "R9");
        do_wb(a, 32'h99, 0, 0, 1);
        drain();
        report();
        $finish;
    end
endmodule